// File: doc/BRIEF.md
# Link Statistics Counter Bank

This block keeps four event tallies for a cell-based serial link PHY: rejected line symbols, cells sent, good cells received, and received cells whose header checksum failed. Separate decode logic supplies one-cycle strobes for these events. The bank turns those strobes into saturating counts of unequal widths.

A host reaches the bank through a small byte-wide register port. To read a counter, the host writes a one-hot value to a select register. That write copies the chosen counter into a 16-bit holding pair and zeroes the counter on the same clock edge. The host then reads the low and high holding bytes at its leisure. For the next reading, of the same counter or another one, the host writes the select register again.

Top module: `link_stat_bank`

## Requirements
- R1: After reset is asserted, every counter is zero and both holding bytes read 0x00.
- R2: The symbol counter is 8 bits wide. It adds one on each clock edge at which `sym_err_stb` is high.
- R3: The transmit counter is 16 bits wide. It adds one on each clock edge at which `tx_cell_stb` is high.
- R4: The receive counter is 16 bits wide. It adds one on an edge where `rx_cell_stb` is high and both `rx_cell_idle` and `rx_cell_hec_bad` are low.
- R5: The checksum-error counter is 5 bits wide. It adds one on an edge where `rx_cell_stb` and `rx_cell_hec_bad` are both high, whatever the value of `rx_cell_idle`.
- R6: Register map:
  - Address 0 is the write-only select register. Bit 0 selects the symbol counter, bit 1 the transmit counter, bit 2 the receive counter and bit 3 the checksum-error counter.
  - Address 1 reads the low holding byte and address 2 reads the high holding byte. Address 3 reads 0x00.
  - `host_rdata` follows `host_addr` combinationally.
  - Writes to addresses 1 to 3 are ignored.
- R7: A write of a valid select value does two things on the same edge: it copies the selected counter into the holding pair, and it clears that counter. A valid value has exactly one of bits 3..0 set and bits 7..4 clear. The copied value is the count before that edge. The other counters are not affected.
- R8: A select write of any other value leaves the holding pair and every counter unchanged. This covers zero, more than one bit set, or any of bits 7..4 set.
- R9: Each counter stops at its all-ones value and never wraps.
- R10: If a counter's event strobe arrives on the same edge as that counter's capture, the counter holds 1 after the edge. The captured value does not include that event.
- R11: The 8-bit and 5-bit counters are zero-extended into the holding pair, so their high byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sym_err_stb | input | 1 | One invalid line symbol seen |
| tx_cell_stb | input | 1 | One cell transmitted |
| rx_cell_stb | input | 1 | One cell received |
| rx_cell_idle | input | 1 | Qualifies `rx_cell_stb`: the cell is idle |
| rx_cell_hec_bad | input | 1 | Qualifies `rx_cell_stb`: the header checksum failed |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational on `host_addr` |

## Verification
The assertions assume the following about the inputs:
- Event strobes are sampled only at clock edges and may be high on any cycle.
- The idle and checksum qualifiers matter only while `rx_cell_stb` is high.
- A select write lasts one cycle per capture.

The stimulus drives every input half a cycle away from the active edge and applies each host write for exactly one cycle. It mixes random event patterns with random select bytes, both one-hot and malformed. Long directed runs push each counter to its ceiling, including the 16-bit transmit counter.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int NUM_CNT = 4;

  typedef enum logic [1:0] {
    CNT_SYM = 2'd0,
    CNT_TX  = 2'd1,
    CNT_RX  = 2'd2,
    CNT_HEC = 2'd3
  } cnt_idx_e;

  localparam logic [1:0] ADDR_SEL    = 2'd0;
  localparam logic [1:0] ADDR_LO     = 2'd1;
  localparam logic [1:0] ADDR_HI     = 2'd2;
  localparam logic [1:0] ADDR_UNUSED = 2'd3;
endpackage

// File: rtl/lsb_sat_counter.sv
module lsb_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = inc_i ? W'(1) : '0;
    end else if (inc_i && (cnt_q != MAXV)) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == W'($past(inc_i)))); // R10

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (cnt_q == MAXV)) |=> (cnt_q == MAXV)); // R9

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && inc_i && (cnt_q != MAXV)) |=> (cnt_q == W'($past(cnt_q) + W'(1)))); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/lsb_sel_dec.sv
module lsb_sel_dec #(
  parameter int DATA_W = 8,
  parameter int N      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      cap_o,
  output logic              cap_any_o
);
  import lsb_pkg::*;

  logic [N-1:0] low_bits;
  logic         upper_clear;
  logic         single_bit;

  assign low_bits    = wdata_i[N-1:0];
  assign upper_clear = (wdata_i[DATA_W-1:N] == '0);
  assign single_bit  = (low_bits != '0) && ((low_bits & (low_bits - N'(1))) == '0);

  always_comb begin
    cap_any_o = wr_i && (addr_i == ADDR_SEL) && upper_clear && single_bit;
    cap_o     = cap_any_o ? low_bits : '0;
  end

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_o)); // R7

  AST_ZERO_SEL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (wdata_i == '0)) |-> (cap_o == '0)); // R8
endmodule

// File: rtl/link_stat_bank.sv
module link_stat_bank #(
  parameter int DATA_W = 8,
  parameter int SYM_W  = 8,
  parameter int CELL_W = 16,
  parameter int HEC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_err_stb,
  input  logic              tx_cell_stb,
  input  logic              rx_cell_stb,
  input  logic              rx_cell_idle,
  input  logic              rx_cell_hec_bad,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  import lsb_pkg::*;

  localparam int HOLD_W = 2 * DATA_W;

  logic [NUM_CNT-1:0] inc_vec;
  logic [NUM_CNT-1:0] cap_vec;
  logic               cap_any;
  logic [HOLD_W-1:0]  cnt_ext [NUM_CNT];
  logic [HOLD_W-1:0]  hold_q;
  logic [HOLD_W-1:0]  hold_d;
  logic [HOLD_W-1:0]  sel_val;

  // event qualification
  always_comb begin
    inc_vec          = '0;
    inc_vec[CNT_SYM] = sym_err_stb;
    inc_vec[CNT_TX]  = tx_cell_stb;
    inc_vec[CNT_RX]  = rx_cell_stb && !rx_cell_idle && !rx_cell_hec_bad;
    inc_vec[CNT_HEC] = rx_cell_stb && rx_cell_hec_bad;
  end

  lsb_sel_dec #(.DATA_W(DATA_W), .N(NUM_CNT)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (host_wr),
    .addr_i    (host_addr),
    .wdata_i   (host_wdata),
    .cap_o     (cap_vec),
    .cap_any_o (cap_any)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int W = (i == int'(CNT_SYM)) ? SYM_W :
                       (i == int'(CNT_HEC)) ? HEC_W : CELL_W;
    logic [W-1:0] q;
    lsb_sat_counter #(.W(W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (inc_vec[i]),
      .clr_i (cap_vec[i]),
      .cnt_o (q)
    );
    assign cnt_ext[i] = HOLD_W'(q);
  end

  // one-hot AND-OR selection of the captured counter
  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      sel_val = sel_val | (cnt_ext[i] & {HOLD_W{cap_vec[i]}});
    end
    hold_d = cap_any ? sel_val : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    unique case (host_addr)
      ADDR_LO: host_rdata = hold_q[DATA_W-1:0];
      ADDR_HI: host_rdata = hold_q[HOLD_W-1:DATA_W];
      default: host_rdata = '0;
    endcase
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr || (host_addr != ADDR_SEL)) |=> $stable(hold_q)); // R8

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_vec[CNT_SYM] && (SYM_W <= DATA_W)) || (cap_vec[CNT_HEC] && (HEC_W <= DATA_W)))
      |=> (hold_q[HOLD_W-1:DATA_W] == '0)); // R11

  AST_RD_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_UNUSED) |-> (host_rdata == '0)); // R6
endmodule

// File: tb/tb_link_stat_bank.sv
module tb_link_stat_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sym_err_stb, tx_cell_stb, rx_cell_stb, rx_cell_idle, rx_cell_hec_bad;
  logic       host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  int mcnt [4];
  int mhold;
  int wid [4] = '{8, 16, 16, 5};

  link_stat_bank dut (
    .clk(clk), .rst_n(rst_n),
    .sym_err_stb(sym_err_stb), .tx_cell_stb(tx_cell_stb),
    .rx_cell_stb(rx_cell_stb), .rx_cell_idle(rx_cell_idle),
    .rx_cell_hec_bad(rx_cell_hec_bad),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic int cmax(int i);
    return (1 << wid[i]) - 1;
  endfunction

  function automatic bit sel_ok(logic [7:0] v);
    return (v[7:4] == 4'h0) && ($countones(v[3:0]) == 1);
  endfunction

  function automatic int sel_idx(logic [7:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(int act, int exp, string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock with given stimulus; bench model advances at the edge
  task automatic cyc(bit s, bit t, bit r, bit idl, bit hb, bit wr, logic [1:0] a, logic [7:0] wd);
    bit ev [4];
    bit cap;
    int ci;
    @(negedge clk);
    sym_err_stb = s; tx_cell_stb = t; rx_cell_stb = r;
    rx_cell_idle = idl; rx_cell_hec_bad = hb;
    host_wr = wr; host_addr = a; host_wdata = wd;
    @(posedge clk);
    ev[0] = s; ev[1] = t; ev[2] = r && !idl && !hb; ev[3] = r && hb;
    cap = wr && (a == 2'd0) && sel_ok(wd);
    ci = sel_idx(wd);
    if (cap) mhold = mcnt[ci];
    for (int i = 0; i < 4; i++) begin
      if (cap && i == ci) mcnt[i] = ev[i] ? 1 : 0;
      else if (ev[i] && mcnt[i] < cmax(i)) mcnt[i]++;
    end
  endtask

  task automatic idle_cyc();
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 8'h00);
  endtask

  task automatic read_hold(string req);
    @(negedge clk);
    sym_err_stb = 0; tx_cell_stb = 0; rx_cell_stb = 0;
    rx_cell_idle = 0; rx_cell_hec_bad = 0; host_wr = 0;
    host_addr = 2'd1; #1;
    chk(int'(host_rdata), mhold & 8'hFF, req);
    host_addr = 2'd2; #1;
    chk(int'(host_rdata), (mhold >> 8) & 8'hFF, req);
    host_addr = 2'd0;
  endtask

  task automatic capture(int i, string req);
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'(1 << i));
    read_hold(req);
  endtask

  initial begin
    sym_err_stb = 0; tx_cell_stb = 0; rx_cell_stb = 0;
    rx_cell_idle = 0; rx_cell_hec_bad = 0;
    host_wr = 0; host_addr = 0; host_wdata = 0;
    for (int i = 0; i < 4; i++) mcnt[i] = 0;
    mhold = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    read_hold("R1");
    for (int i = 0; i < 4; i++) capture(i, "R1");

    // R6: unused address and ignored writes to read addresses
    @(negedge clk); host_addr = 2'd3; #1;
    chk(int'(host_rdata), 0, "R6");
    repeat (5) cyc(1, 1, 1, 0, 0, 0, 2'd0, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 2'd1, 8'h01);
    cyc(0, 0, 0, 0, 0, 1, 2'd2, 8'h02);
    read_hold("R6");

    // R2 R3 R4 R5 directed counts
    capture(0, "R2");
    capture(1, "R3");
    repeat (4) cyc(0, 0, 1, 0, 0, 0, 2'd0, 8'h00);
    repeat (3) cyc(0, 0, 1, 1, 0, 0, 2'd0, 8'h00);
    repeat (2) cyc(0, 0, 1, 0, 1, 0, 2'd0, 8'h00);
    cyc(0, 0, 1, 1, 1, 0, 2'd0, 8'h00);
    capture(2, "R4");
    capture(3, "R5");
    chk(mhold, 3, "R5");

    // R8: malformed selects change nothing
    repeat (7) cyc(1, 0, 0, 0, 0, 0, 2'd0, 8'h00);
    capture(0, "R8");
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 2'd0, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'h00);
    read_hold("R8");
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'h03);
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'h11);
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'h20);
    read_hold("R8");
    capture(0, "R8");
    chk(mhold, 3, "R8");

    // R10: event coincident with capture restarts at one
    repeat (6) cyc(0, 1, 0, 0, 0, 0, 2'd0, 8'h00);
    cyc(0, 1, 0, 0, 0, 1, 2'd0, 8'h02);
    read_hold("R10");
    chk(mhold, 6, "R10");
    capture(1, "R10");
    chk(mhold, 1, "R10");

    // R9 R11: saturation of every counter
    repeat (300) cyc(1, 0, 1, 0, 1, 0, 2'd0, 8'h00);
    capture(0, "R9");
    chk(mhold, 255, "R11");
    capture(3, "R9");
    chk(mhold, 31, "R11");
    repeat (65600) cyc(0, 1, 1, 0, 0, 0, 2'd0, 8'h00);
    capture(1, "R9");
    chk(mhold, 65535, "R9");
    capture(2, "R9");
    chk(mhold, 65535, "R9");

    // random mix: R7 captures and R8 malformed selects
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] wd;
      bit wr;
      wr = ($urandom % 16) == 0;
      if ($urandom % 2) wd = 8'(1 << ($urandom % 4));
      else              wd = 8'($urandom);
      cyc(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
          ($urandom % 4) == 0, ($urandom % 5) == 0, wr, 2'd0, wd);
      if (wr) read_hold(sel_ok(wd) ? "R7" : "R8");
    end
    for (int i = 0; i < 4; i++) capture(i, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule